// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block holds fifteen 64-bit general-purpose registers, each selected by a 4-bit identifier. Two read ports, each with its own identifier input and data output, show the addressed registers combinationally: a change on a read identifier reaches the data output within the same cycle, without waiting for a clock edge. One write port takes an identifier, a data word and an enable. The selected register is loaded at the next rising clock edge.

The all-ones identifier (0xF) is reserved and stands for "no register". A write aimed at it changes nothing, even with the enable high. A read of it returns zero. A one-hot load decoder steers each write. When the enable is low, or the identifier is the reserved one, every load line stays low. A synchronous active-low reset clears all registers. A read of the register being written in the same cycle gives the old contents until the edge; this block has no write-to-read bypass.

Top module: `dual_read_regfile`

## Requirements
- R1: When rst_n is low at a rising clock edge, all fifteen registers become 0, and reads of every identifier return 0 afterwards.
- R2: When wr_en is 1 and wr_id is in 0x0..0xE at a rising edge, the register wr_id takes wr_data, and both read ports show it after that edge.
- R3: A write changes only the register named by wr_id; every other register keeps its value.
- R4: When wr_en is 0 at a rising edge, no register changes.
- R5: When wr_id is 0xF, no register changes, even with wr_en at 1.
- R6: A read port whose identifier is 0xF outputs 0.
- R7: The two read ports are independent. In the same cycle they may show two different registers or the same register.
- R8: Read data is combinational: it follows a change of the read identifier within the same cycle, with no clock edge.
- R9: A read of the register being written shows the old value before the rising edge and the new value after it.
- R10: All 64 data bits are stored and returned exactly, including the all-ones value and values with only the top and bottom bits set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_id | input | 4 | Register identifier for read port A (0xF = none) |
| rd_a_data | output | 64 | Contents of the register named by rd_a_id |
| rd_b_id | input | 4 | Register identifier for read port B (0xF = none) |
| rd_b_data | output | 64 | Contents of the register named by rd_b_id |
| wr_en | input | 1 | Write enable |
| wr_id | input | 4 | Destination register identifier (0xF = none) |
| wr_data | input | 64 | Data to be written |

## Verification
Read results are due in the cycle of the stimulus. The bench changes the read identifiers on the falling clock edge and samples the data 1 ns later, before any rising edge. A write or a reset takes effect at the next rising edge, so those results are sampled at the falling edge after it. For the register under write, the bench also reads the old contents before that edge, which checks that there is no bypass. After each write vector, every identifier is read back on both ports. This shows that disabled and reserved-identifier writes left all fifteen registers unchanged.

// File: rtl/rf_pkg.sv
// Shared constants and helpers for the two-read one-write register file.
// Assumes identifiers are unsigned and the all-ones identifier is reserved.
package rf_pkg;
    localparam int RF_NUM_REGS = 15;
    localparam int RF_DATA_W   = 64;
    localparam int RF_ID_W     = 4;

    // True when an identifier names a real register.
    function automatic logic id_is_real(input logic [RF_ID_W-1:0] id, input int num_regs);
        return (int'(id) < num_regs);
    endfunction
endpackage

// File: rtl/rf_wr_decoder.sv
// Write-address decoder: turns (enable, identifier) into one load line per
// register. Assumes NUM_REGS < 2**ID_W so that at least the all-ones
// identifier decodes to no register.
module rf_wr_decoder #(
    parameter int NUM_REGS = rf_pkg::RF_NUM_REGS,
    parameter int ID_W     = rf_pkg::RF_ID_W
) (
    input  logic                wr_en,
    input  logic [ID_W-1:0]     wr_id,
    output logic [NUM_REGS-1:0] load
);
    // One comparator per register; reserved identifiers match none.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
        assign load[g] = wr_en && (wr_id == ID_W'(g));
    end
endmodule

// File: rtl/rf_storage.sv
// Register array: one DATA_W-bit register per load line, cleared by a
// synchronous active-low reset. Assumes at most one load line is high.
module rf_storage #(
    parameter int NUM_REGS = rf_pkg::RF_NUM_REGS,
    parameter int DATA_W   = rf_pkg::RF_DATA_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_REGS-1:0]              load,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] q;
        // Clear on reset, otherwise load when this register's line is high.
        always_ff @(posedge clk) begin
            if (!rst_n)       q <= '0;
            else if (load[g]) q <= wr_data;
        end
        assign regs[g] = q;
    end
endmodule

// File: rtl/rf_read_mux.sv
// Combinational read port: selects one register by identifier, and gives
// zero for any identifier at or above NUM_REGS (the reserved one).
module rf_read_mux #(
    parameter int NUM_REGS = rf_pkg::RF_NUM_REGS,
    parameter int DATA_W   = rf_pkg::RF_DATA_W,
    parameter int ID_W     = rf_pkg::RF_ID_W
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic [ID_W-1:0]                 rd_id,
    output logic [DATA_W-1:0]               rd_data
);
    // Select the addressed word; the reserved identifier reads as zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_id == ID_W'(i)) rd_data = regs[i];
        end
    end
endmodule

// File: rtl/dual_read_regfile.sv
// Register file top: fifteen registers, two combinational read ports, one
// clocked write port gated by an enable and a real-register check.
// Assumes synchronous active-low reset; a read in the cycle of a write
// returns the value held before the edge (no bypass).
module dual_read_regfile #(
    parameter int NUM_REGS = rf_pkg::RF_NUM_REGS,
    parameter int DATA_W   = rf_pkg::RF_DATA_W,
    parameter int ID_W     = rf_pkg::RF_ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   rd_a_id,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ID_W-1:0]   rd_b_id,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [DATA_W-1:0] wr_data
);
    localparam logic [ID_W-1:0] NULL_ID = '1;

    logic [NUM_REGS-1:0]             load;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

    rf_wr_decoder #(.NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_dec (
        .wr_en (wr_en),
        .wr_id (wr_id),
        .load  (load)
    );

    // R3: the decoder never loads more than one register.
    assert_onehot_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load));

    rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .wr_data (wr_data),
        .regs    (regs_q)
    );

    // R2: an enabled write to a real register lands at the next edge.
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rf_pkg::id_is_real(wr_id, NUM_REGS))
        |=> (regs_q[$past(wr_id)] == $past(wr_data)));

    // R4: a disabled cycle leaves the whole array as it was.
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));

    // R5: a write to the reserved identifier leaves the array as it was.
    assert_null_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_id == NULL_ID) |=> $stable(regs_q));

    rf_read_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ID_W(ID_W)) u_rd_a (
        .regs    (regs_q),
        .rd_id   (rd_a_id),
        .rd_data (rd_a_data)
    );

    rf_read_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ID_W(ID_W)) u_rd_b (
        .regs    (regs_q),
        .rd_id   (rd_b_id),
        .rd_data (rd_b_data)
    );

    // R6: both ports read zero for the reserved identifier.
    assert_null_read_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_id == NULL_ID) |-> (rd_a_data == '0));
    assert_null_read_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_id == NULL_ID) |-> (rd_b_data == '0));
endmodule

// File: tb/sim_dual_read_regfile.sv
`timescale 1ns/1ps
module sim_dual_read_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_id = 4'h0, rd_b_id = 4'h0, wr_id = 4'h0;
    logic [63:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [63:0] model [16];

    always #2.5 clk = ~clk;

    dual_read_regfile u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_a_id(rd_a_id), .rd_a_data(rd_a_data),
        .rd_b_id(rd_b_id), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_id(wr_id), .wr_data(wr_data)
    );

    // Fields of each entry: {enable, id, data}.
    localparam logic [68:0] WR_VEC [8] = '{
        {1'b1, 4'h0, 64'h0123_4567_89AB_CDEF},
        {1'b1, 4'hE, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b1, 4'h7, 64'h8000_0000_0000_0001},
        {1'b0, 4'h3, 64'hDEAD_BEEF_CAFE_F00D},
        {1'b1, 4'hF, 64'h5555_5555_5555_5555},
        {1'b1, 4'h7, 64'hAAAA_AAAA_AAAA_AAAA},
        {1'b1, 4'h3, 64'h0000_0000_0000_0042},
        {1'b1, 4'h0, 64'h0000_0000_0000_0000}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Read every identifier on both ports and compare with the model.
    task automatic sweep(input string req);
        for (int i = 0; i < 16; i++) begin
            rd_a_id = 4'(i);
            rd_b_id = 4'(15 - i);
            #0.2;
            chk(req, rd_a_data, model[i]);
            chk(req, rd_b_data, model[15 - i]);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // Reset state, all identifiers, both ports.
        sweep("R1 reset");

        // Vector table walk.
        for (int v = 0; v < 8; v++) begin
            logic        en;
            logic [3:0]  id;
            logic [63:0] d;
            string       tag;
            {en, id, d} = WR_VEC[v];
            tag = !en ? "R4 disabled" : (id == 4'hF) ? "R5 null write" : "R2 write";
            @(negedge clk);
            wr_en = en; wr_id = id; wr_data = d;
            rd_a_id = id; rd_b_id = id;
            #1;
            chk("R9 old before edge", rd_a_data, model[id]);
            @(posedge clk);
            @(negedge clk);
            wr_en = 1'b0;
            if (en && id != 4'hF) model[id] = d;
            #0.5;
            chk(tag, rd_a_data, model[id]);
            chk("R9 new after edge", rd_b_data, model[id]);
            sweep("R3 others unchanged");
        end

        // R10: full-width patterns held exactly.
        @(negedge clk);
        rd_a_id = 4'hE; rd_b_id = 4'h3;
        #0.5;
        chk("R10 all ones", rd_a_data, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R7 distinct ports", rd_b_data, 64'h42);

        // R8: read follows identifier mid-cycle with no clock edge.
        rd_a_id = 4'h7;
        #0.3;
        chk("R8 comb read", rd_a_data, 64'hAAAA_AAAA_AAAA_AAAA);
        rd_b_id = 4'h7;
        #0.3;
        chk("R7 same register", rd_b_data, rd_a_data);

        // R6: reserved identifier reads zero on both ports.
        rd_a_id = 4'hF; rd_b_id = 4'hF;
        #0.3;
        chk("R6 null read a", rd_a_data, 64'h0);
        chk("R6 null read b", rd_b_data, 64'h0);

        // R1: reset again after data is present.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) model[i] = '0;
        sweep("R1 reset clears");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule